// File: doc/BRIEF.md
# Bit-banged serial pin controller

This block gives firmware direct control of five serial-interface pins: one clock line, one data line and three active-low select lines. Each pin is brought out as an output value, an output enable and a sampled input. A two-entry register file on a simple synchronous bus sets the pin levels and directions. Software produces a serial transfer by writing the control register over and over.

The clock line can hold a static level. It can also fire a single pulse of fixed length after every control-register write. The pulse direction comes from the stored clock-level bit. Reads of the control register return the live, synchronized pin levels and not the stored bits. Software can therefore observe the lines when a pin is released to an external driver.

Top module: `serial_pin_ctrl`

## Requirements
- R1: When the clock-enable bit (direction register bit 4) is 0, `sck_oe_o` is 0, whatever the clock level and pulse-mode bits hold.
- R2: With the clock enabled and the pulse-mode bit (control bit 3) at 0, `sck_o` holds the clock-level bit (control bit 2) steadily from the cycle after the write.
- R3: With the clock enabled and the pulse-mode bit at 1, the clock line idles at the clock-level bit. Each control write inverts the line for the pulse: a high pulse from a low idle when the level is 0, and a low pulse from a high idle when it is 1.
- R4: The pulse starts in the cycle after the write is accepted and lasts `PULSE_CYCLES` cycles (default 2). A control write during a pulse restarts the full length.
- R5: After reset the clock, data and select outputs are all enabled, with clock low, data low and each select line high. The direction register reads 0x1E.
- R6: The data pin is an output when the data-direction bit (control bit 1) is 0 and an input when it is 1. As an output it carries the data-level bit (control bit 0).
- R7: Select line k (k = 0..2) is an output when direction bit k+1 is 1 and an input when it is 0. As an output it carries the inverse of control bit k+4.
- R8: Control reads (address 0) return the synchronized pin levels at bits 0 (data), 2 (clock) and 6:4 (select lines, not inverted), two cycles behind the pins.
- R9: Control reads return the stored data-direction and pulse-mode bits at bits 1 and 3. Bit 7 reads 0. Direction-register reads (address 1) return the clock enable at bit 4 and the select enables at bits 3:1, with all other bits 0.
- R10: Reads from addresses other than 0 and 1 return 0, and writes to them change no register and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i |
| sck_o | output | 1 | Clock line output value |
| sck_oe_o | output | 1 | Clock line output enable |
| sck_i | input | 1 | Clock line sampled level |
| sda_o | output | 1 | Data line output value |
| sda_oe_o | output | 1 | Data line output enable |
| sda_i | input | 1 | Data line sampled level |
| sel_n_o | output | 3 | Select lines output values |
| sel_n_oe_o | output | 3 | Select lines output enables |
| sel_n_i | input | 3 | Select lines sampled levels |

## Verification
The bench checks pulse polarity in both idle levels. A design with the XOR reversed would pulse the wrong way or sit at the wrong idle level. A second write lands in the middle of a pulse. A counter that ignores reloads would end the pulse one cycle early. With a pin released, readback must show the externally driven level and not the stored bit, and the value must change exactly on the second cycle. A missing or extra synchronizer stage, or a readback that returns register contents, shows up there. The bench also drops one select-line enable and writes to unmapped addresses. A decoder that ignores upper address bits would then corrupt the live registers.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int NUM_SEL = 3;

  // control register bit positions
  localparam int CTL_DAT_LVL = 0;
  localparam int CTL_DAT_IN  = 1;
  localparam int CTL_CLK_LVL = 2;
  localparam int CTL_CLK_PLS = 3;
  localparam int CTL_SEL_LO  = 4;

  // direction register bit positions
  localparam int DIR_SEL_LO  = 1;
  localparam int DIR_CLK_EN  = 4;

  localparam int NUM_PINS = NUM_SEL + 2;

  typedef struct packed {
    logic               clk_en;
    logic [NUM_SEL-1:0] sel_en;
    logic [NUM_SEL-1:0] sel;
    logic               clk_pulse;
    logic               clk_lvl;
    logic               dat_in;
    logic               dat_lvl;
  } cfg_t;

  typedef struct packed {
    logic [NUM_SEL-1:0] sel_n;
    logic               sck;
    logic               sda;
  } pins_t;
endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spc_pulse_gen.sv
module spc_pulse_gen #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (fire_i) cnt_q <= CNT_LOAD;   // restart on every write
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_pulse_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> (active_o && cnt_q == CNT_LOAD));
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LOAD);
endmodule

// File: rtl/spc_regs.sv
module spc_regs
  import spc_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  pins_t             pins_sync_i,
  output logic [DATA_W-1:0] rdata_o,
  output cfg_t              cfg_o,
  output logic              ctl_wr_o
);
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DIR = ADDR_W'(1);

  cfg_t cfg_q;
  logic dir_wr;

  assign ctl_wr_o = wr_en_i && (addr_i == ADDR_CTL);
  assign dir_wr   = wr_en_i && (addr_i == ADDR_DIR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.dat_lvl   <= 1'b0;
      cfg_q.dat_in    <= 1'b0;
      cfg_q.clk_lvl   <= 1'b0;
      cfg_q.clk_pulse <= 1'b0;
      cfg_q.sel       <= '0;
      cfg_q.clk_en    <= 1'b1;
      cfg_q.sel_en    <= '1;
    end else begin
      if (ctl_wr_o) begin
        cfg_q.dat_lvl   <= wdata_i[CTL_DAT_LVL];
        cfg_q.dat_in    <= wdata_i[CTL_DAT_IN];
        cfg_q.clk_lvl   <= wdata_i[CTL_CLK_LVL];
        cfg_q.clk_pulse <= wdata_i[CTL_CLK_PLS];
        cfg_q.sel       <= wdata_i[CTL_SEL_LO +: NUM_SEL];
      end
      if (dir_wr) begin
        cfg_q.clk_en <= wdata_i[DIR_CLK_EN];
        cfg_q.sel_en <= wdata_i[DIR_SEL_LO +: NUM_SEL];
      end
    end
  end

  assign cfg_o = cfg_q;

  // readback: live pin levels for data, clock and selects; stored bits otherwise
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTL) begin
      rdata_o[CTL_DAT_LVL]             = pins_sync_i.sda;
      rdata_o[CTL_DAT_IN]              = cfg_q.dat_in;
      rdata_o[CTL_CLK_LVL]             = pins_sync_i.sck;
      rdata_o[CTL_CLK_PLS]             = cfg_q.clk_pulse;
      rdata_o[CTL_SEL_LO +: NUM_SEL]   = pins_sync_i.sel_n;
    end else if (addr_i == ADDR_DIR) begin
      rdata_o[DIR_CLK_EN]              = cfg_q.clk_en;
      rdata_o[DIR_SEL_LO +: NUM_SEL]   = cfg_q.sel_en;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[DATA_W-1:CTL_SEL_LO+NUM_SEL], wdata_i[0]};

  assert_unmapped_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != ADDR_CTL && addr_i != ADDR_DIR) |=> $stable(cfg_q));
  assert_dir_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr |=> ($stable(cfg_q.clk_en) && $stable(cfg_q.sel_en)));
endmodule

// File: rtl/serial_pin_ctrl.sv
module serial_pin_ctrl
  import spc_pkg::*;
#(
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               sck_o,
  output logic               sck_oe_o,
  input  logic               sck_i,
  output logic               sda_o,
  output logic               sda_oe_o,
  input  logic               sda_i,
  output logic [NUM_SEL-1:0] sel_n_o,
  output logic [NUM_SEL-1:0] sel_n_oe_o,
  input  logic [NUM_SEL-1:0] sel_n_i
);
  cfg_t  cfg;
  pins_t pins_raw, pins_sync;
  logic  ctl_wr;
  logic  pulse_active;

  assign pins_raw = '{sel_n: sel_n_i, sck: sck_i, sda: sda_i};

  spc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_sync)
  );

  spc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .pins_sync_i (pins_sync),
    .rdata_o     (rdata_o),
    .cfg_o       (cfg),
    .ctl_wr_o    (ctl_wr)
  );

  spc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (ctl_wr),
    .active_o (pulse_active)
  );

  // pulse inverts the idle level for its duration
  assign sck_oe_o   = cfg.clk_en;
  assign sck_o      = cfg.clk_lvl ^ (cfg.clk_pulse & pulse_active);
  assign sda_oe_o   = ~cfg.dat_in;
  assign sda_o      = cfg.dat_lvl;
  assign sel_n_oe_o = cfg.sel_en;
  assign sel_n_o    = ~cfg.sel;

  assert_clk_released_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1) && !wdata_i[DIR_CLK_EN]) |=> !sck_oe_o);
  assert_steady_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && !wdata_i[CTL_CLK_PLS]) |=> (sck_o == $past(wdata_i[CTL_CLK_LVL])));
  assert_pulse_polarity_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wr && wdata_i[CTL_CLK_PLS]) |=> (sck_o == !$past(wdata_i[CTL_CLK_LVL])));
  assert_data_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> (sda_oe_o == !$past(wdata_i[CTL_DAT_IN]) && sda_o == $past(wdata_i[CTL_DAT_LVL])));
  assert_sel_invert_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr |=> (sel_n_o == ~$past(wdata_i[CTL_SEL_LO +: NUM_SEL])));
endmodule

// File: tb/tb_serial_pin_ctrl.sv
module tb_serial_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck_o, sck_oe, sck_i, sda_o, sda_oe, sda_i;
  logic [2:0] sel_n_o, sel_n_oe, sel_n_i;
  logic       ext_sck = 1'b0, ext_sda = 1'b0;
  logic [2:0] ext_sel = 3'b000;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // external line model: released pins take the external level
  assign sck_i   = sck_oe ? sck_o : ext_sck;
  assign sda_i   = sda_oe ? sda_o : ext_sda;
  assign sel_n_i = (sel_n_oe & sel_n_o) | (~sel_n_oe & ext_sel);

  serial_pin_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .sck_o(sck_o), .sck_oe_o(sck_oe), .sck_i(sck_i),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .sda_i(sda_i),
    .sel_n_o(sel_n_o), .sel_n_oe_o(sel_n_oe), .sel_n_i(sel_n_i)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
    addr = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R5 sck_oe", {7'd0, sck_oe}, 8'h01);
    chk("R5 sck", {7'd0, sck_o}, 8'h00);
    chk("R5 sda_oe/sda", {6'd0, sda_oe, sda_o}, 8'h02);
    chk("R5 sel_oe/sel", {2'd0, sel_n_oe, sel_n_o}, 8'h3F);
    rd(2'd1, d); chk("R5 dir reg", d, 8'h1E);
    rd(2'd0, d); chk("R8 reset readback", d, 8'h70);
  endtask

  task automatic t_steady();
    wr(2'd0, 8'h04);
    chk("R2 high c1", {7'd0, sck_o}, 8'h01);
    idle(2); chk("R2 high held", {7'd0, sck_o}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R2 low", {7'd0, sck_o}, 8'h00);
  endtask

  task automatic t_pulse();
    wr(2'd0, 8'h08);
    chk("R3 high pulse c1", {7'd0, sck_o}, 8'h01);
    idle(1); chk("R4 high pulse c2", {7'd0, sck_o}, 8'h01);
    idle(1); chk("R4 pulse end low idle", {7'd0, sck_o}, 8'h00);
    wr(2'd0, 8'h0C);
    chk("R3 low pulse c1", {7'd0, sck_o}, 8'h00);
    idle(1); chk("R4 low pulse c2", {7'd0, sck_o}, 8'h00);
    idle(1); chk("R3 high idle", {7'd0, sck_o}, 8'h01);
  endtask

  task automatic t_restart();
    wr(2'd0, 8'h08);
    chk("R4 restart c1", {7'd0, sck_o}, 8'h01);
    wr(2'd0, 8'h08);
    chk("R4 restart c2", {7'd0, sck_o}, 8'h01);
    idle(1); chk("R4 restart c3", {7'd0, sck_o}, 8'h01);
    idle(1); chk("R4 restart end", {7'd0, sck_o}, 8'h00);
  endtask

  task automatic t_clk_input();
    logic [7:0] d;
    wr(2'd1, 8'h0E);
    chk("R1 released", {7'd0, sck_oe}, 8'h00);
    wr(2'd0, 8'h0C);
    chk("R1 released during pulse", {7'd0, sck_oe}, 8'h00);
    ext_sck = 1'b1;
    idle(3);
    rd(2'd0, d); chk("R8 clock input readback", d & 8'h04, 8'h04);
    ext_sck = 1'b0;
    idle(3);
    rd(2'd0, d); chk("R8 clock input low", d & 8'h04, 8'h00);
    wr(2'd1, 8'h1E);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_data();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    chk("R6 data out high", {6'd0, sda_oe, sda_o}, 8'h03);
    wr(2'd0, 8'h02);
    chk("R6 data released", {7'd0, sda_oe}, 8'h00);
    idle(3);
    ext_sda = 1'b1;
    idle(1);
    rd(2'd0, d); chk("R8 lag one cycle", d & 8'h01, 8'h00);
    idle(1);
    rd(2'd0, d); chk("R8 lag two cycles", d & 8'h01, 8'h01);
    chk("R9 stored dir bit", d & 8'h0A, 8'h02);
    ext_sda = 1'b0;
    wr(2'd0, 8'h08);
    idle(3);
    rd(2'd0, d); chk("R9 stored pulse bit", d & 8'h8A, 8'h08);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_select();
    logic [7:0] d;
    wr(2'd0, 8'h50);
    chk("R7 sel inverted", {5'd0, sel_n_o}, 8'h02);
    idle(3);
    rd(2'd0, d); chk("R8 sel readback uninverted", d, 8'h20);
    ext_sel = 3'b000;
    wr(2'd1, 8'h1A);
    chk("R7 sel1 released", {5'd0, sel_n_oe}, 8'h05);
    idle(3);
    rd(2'd0, d); chk("R8 released sel readback", d & 8'h70, 8'h00);
    rd(2'd1, d); chk("R9 dir readback", d, 8'h1A);
    wr(2'd1, 8'h1E);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    rd(2'd2, d); chk("R10 unmapped read", d, 8'h00);
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'h00);
    chk("R10 pins unchanged", {sck_oe, sck_o, sda_oe, sda_o, 1'b0, sel_n_o}, 8'hA7);
    rd(2'd1, d); chk("R10 dir unchanged", d, 8'h1E);
    idle(3);
    rd(2'd0, d); chk("R10 ctl unchanged", d, 8'h70);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_steady();
    t_pulse();
    t_restart();
    t_clk_input();
    t_data();
    t_select();
    t_unmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule